// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block drives the bus side of a small 8-bit processor core, one instruction at a time. Each instruction starts with an opcode fetch. The block then reads the fetched opcode and schedules the bus cycles that follow it. It works through those cycles one by one. For each cycle it raises a request to a separate bus-cycle unit and holds it until that unit signals completion.

Four instruction forms are supported:

- a load of an immediate byte,
- a move from memory at the address held in a register pair,
- an input from an 8-bit port,
- an output to an 8-bit port.

The sequencer keeps the program counter. It captures operand bytes and port numbers, and forms the I/O address from the port byte. It adds up the clock states that each cycle costs. When an instruction ends it reports the total, along with any byte that was read. An opcode outside the supported set raises a one-cycle error flag, and the sequencer starts a new fetch.

Top module: `mcyc_seq`

## Requirements
- R1: While reset is held, no request is raised and the program counter equals RESET_PC (default 0). The first request after reset is an opcode fetch (bus_kind 0) at RESET_PC.
- R2: The first bus cycle after every completed instruction, and after every error, is an opcode fetch (bus_kind 0) at the current program counter.
- R3: A request stays raised, with kind, address and write data unchanged, until bus_done is seen. In the cycle after bus_done the request is low.
- R4: Opcode 0x3E runs two cycles: a fetch at PC, then a memory read (bus_kind 1) at PC+1. The byte read is returned on result_data, and the instruction costs 7 states.
- R5: Opcode 0x46 runs two cycles: a fetch, then a memory read (bus_kind 1) at pair_addr. The byte read is returned on result_data, the cost is 7 states, and the program counter advances by one only.
- R6: Opcode 0xDB runs three cycles: a fetch, a memory read of the port byte at PC+1, then an I/O read (bus_kind 3) at {port, port}. The I/O byte is returned on result_data, and the cost is 10 states.
- R7: Opcode 0xD3 runs three cycles: a fetch, a memory read of the port byte, then an I/O write (bus_kind 4) at {port, port} with bus_wdata equal to acc_data. No result is reported (result_valid 0), and the cost is 10 states.
- R8: The program counter increases by one after each completed bus cycle whose address came from the program counter (the opcode or an operand byte). It does not change on any other cycle.
- R9: An opcode outside the supported set raises err_flag for exactly one cycle, without instr_done. The next request is a fetch at the following address.
- R10: instr_tstates, valid while instr_done is high, equals T_FETCH (4) plus T_BUS (3) for each later cycle of the instruction. The count restarts for every instruction, including after an error.
- R11: result_valid is high only together with instr_done, and only for the forms that read data (0x3E, 0x46, 0xDB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Bus cycle request, held until done |
| bus_kind | output | 3 | 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| bus_addr | output | AW | Address of the requested cycle |
| bus_wdata | output | DW | Write data for write cycles, zero otherwise |
| bus_done | input | 1 | One-cycle completion pulse from the bus unit |
| bus_rdata | input | DW | Read data, valid with bus_done |
| pair_addr | input | AW | Register-pair address for the indirect move |
| acc_data | input | DW | Accumulator byte for port output |
| pc | output | AW | Program counter |
| instr_done | output | 1 | One-cycle pulse at instruction end |
| instr_tstates | output | TW | Clock states used by the instruction just ended |
| result_valid | output | 1 | result_data holds a byte read by the instruction |
| result_data | output | DW | Byte read by the instruction |
| err_flag | output | 1 | One-cycle pulse on an unsupported opcode |

## Verification
The assertions assume that the bus unit raises bus_done only while bus_req is high, and for a single cycle per request. They also assume that bus_rdata is valid in that same cycle. The bench's bus responder follows this rule. It counts a chosen latency while the request is high, pulses done once, and clears its state whenever the request is low. The latency changes between scenarios (zero to three wait cycles), so that both back-to-back and stretched requests are covered.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } kind_e;

   typedef enum logic [1:0] {
      A_PC   = 2'd0,
      A_PAIR = 2'd1,
      A_PORT = 2'd2
   } asel_e;

   typedef struct packed {
      kind_e kind;
      asel_e asel;
   } step_t;
endpackage

// File: rtl/mcyc_decode.sv
module mcyc_decode
   import mcyc_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NF      = 5,
   parameter int CW      = 3,
   parameter int OPC_MVI = 8'h3E,
   parameter int OPC_MOV = 8'h46,
   parameter int OPC_IN  = 8'hDB,
   parameter int OPC_OUT = 8'hD3
) (
   input  logic [DW-1:0]   opcode,
   output logic            valid,
   output logic            want_result,
   output logic [CW-1:0]   n_follow,
   output step_t [NF-1:0]  plan
);
   if (NF < 2) begin : g_nf_chk
      $error("mcyc_decode: NF must allow two follow-on cycles");
   end

   localparam logic [DW-1:0] C_MVI = DW'(OPC_MVI);
   localparam logic [DW-1:0] C_MOV = DW'(OPC_MOV);
   localparam logic [DW-1:0] C_IN  = DW'(OPC_IN);
   localparam logic [DW-1:0] C_OUT = DW'(OPC_OUT);

   always_comb begin
      valid       = 1'b1;
      want_result = 1'b1;
      n_follow    = '0;
      for (int j = 0; j < NF; j++) begin
         plan[j] = '{kind: K_MRD, asel: A_PC};
      end
      if (opcode == C_MVI) begin
         n_follow = CW'(1);
         plan[0]  = '{kind: K_MRD, asel: A_PC};
      end else if (opcode == C_MOV) begin
         n_follow = CW'(1);
         plan[0]  = '{kind: K_MRD, asel: A_PAIR};
      end else if (opcode == C_IN) begin
         n_follow = CW'(2);
         plan[0]  = '{kind: K_MRD, asel: A_PC};
         plan[1]  = '{kind: K_IORD, asel: A_PORT};
      end else if (opcode == C_OUT) begin
         n_follow    = CW'(2);
         want_result = 1'b0;
         plan[0]     = '{kind: K_MRD, asel: A_PC};
         plan[1]     = '{kind: K_IOWR, asel: A_PORT};
      end else begin
         valid       = 1'b0;
         want_result = 1'b0;
      end
   end
endmodule

// File: rtl/mcyc_addr.sv
module mcyc_addr
   import mcyc_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int RESET_PC    = 0,
   parameter bit PORT_MIRROR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  asel_e         asel,
   input  logic          pc_inc,
   input  logic [AW-1:0] pair,
   input  logic [DW-1:0] port,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] pc
);
   logic [AW-1:0] port_addr;

   if (PORT_MIRROR) begin : g_mirror
      if (AW != 2 * DW) begin : g_chk
         $error("mcyc_addr: mirrored port needs AW == 2*DW");
      end
      assign port_addr = {port, port};
   end else begin : g_zext
      if (AW <= DW) begin : g_chk
         $error("mcyc_addr: AW must exceed DW");
      end
      assign port_addr = {{(AW-DW){1'b0}}, port};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= AW'(RESET_PC);
      end else if (pc_inc) begin
         pc <= pc + 1'b1;
      end
   end

   always_comb begin
      unique case (asel)
         A_PAIR:  addr = pair;
         A_PORT:  addr = port_addr;
         default: addr = pc;
      endcase
   end
endmodule

// File: rtl/mcyc_tacc.sv
module mcyc_tacc #(
   parameter int TW      = 5,
   parameter int T_FETCH = 4,
   parameter int T_BUS   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add_en,
   input  logic          is_fetch,
   input  logic          clear,
   output logic [TW-1:0] total
);
   localparam logic [TW-1:0] CF = TW'(T_FETCH);
   localparam logic [TW-1:0] CB = TW'(T_BUS);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         total <= '0;
      end else if (add_en) begin
         total <= total + (is_fetch ? CF : CB);
      end
   end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int MAX_CYC     = 6,
   parameter int T_FETCH     = 4,
   parameter int T_BUS       = 3,
   parameter int TW          = $clog2(T_FETCH + T_BUS * (MAX_CYC - 1) + 1),
   parameter int RESET_PC    = 0,
   parameter bit PORT_MIRROR = 1'b1,
   parameter int OPC_MVI     = 8'h3E,
   parameter int OPC_MOV     = 8'h46,
   parameter int OPC_IN      = 8'hDB,
   parameter int OPC_OUT     = 8'hD3
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          bus_req,
   output logic [2:0]    bus_kind,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_done,
   input  logic [DW-1:0] bus_rdata,
   input  logic [AW-1:0] pair_addr,
   input  logic [DW-1:0] acc_data,
   output logic [AW-1:0] pc,
   output logic          instr_done,
   output logic [TW-1:0] instr_tstates,
   output logic          result_valid,
   output logic [DW-1:0] result_data,
   output logic          err_flag
);
   localparam int NF = MAX_CYC - 1;
   localparam int CW = $clog2(MAX_CYC);

   if (MAX_CYC < 3 || MAX_CYC > 6) begin : g_cyc_chk
      $error("mcyc_seq: MAX_CYC must be 3..6");
   end
   if (TW < $clog2(T_FETCH + T_BUS * (MAX_CYC - 1) + 1)) begin : g_tw_chk
      $error("mcyc_seq: TW too narrow for the state count");
   end
   if (T_FETCH < 1 || T_BUS < 1) begin : g_t_chk
      $error("mcyc_seq: state costs must be positive");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_NEXT} st_e;

   st_e            st_q;
   logic [CW-1:0]  idx_q;
   logic [DW-1:0]  opcode_q;
   logic [DW-1:0]  data_q;

   logic           dec_valid;
   logic           dec_want;
   logic [CW-1:0]  dec_nf;
   step_t [NF-1:0] dec_plan;
   step_t          cur;
   logic [CW-1:0]  slot;
   logic           cyc_done;
   logic           is_last;
   logic           is_bad;
   logic [AW-1:0]  addr_w;

   mcyc_decode #(
      .DW(DW), .NF(NF), .CW(CW),
      .OPC_MVI(OPC_MVI), .OPC_MOV(OPC_MOV), .OPC_IN(OPC_IN), .OPC_OUT(OPC_OUT)
   ) u_dec (
      .opcode      (opcode_q),
      .valid       (dec_valid),
      .want_result (dec_want),
      .n_follow    (dec_nf),
      .plan        (dec_plan)
   );

   assign slot = idx_q - 1'b1;

   always_comb begin
      cur = '{kind: K_FETCH, asel: A_PC};
      if (idx_q != '0) begin
         for (int j = 0; j < NF; j++) begin
            if (slot == CW'(j)) cur = dec_plan[j];
         end
      end
   end

   assign cyc_done = (st_q == ST_ISSUE) && bus_done;
   assign is_bad   = (st_q == ST_NEXT) && (idx_q == '0) && !dec_valid;
   assign is_last  = (st_q == ST_NEXT) && !is_bad && (idx_q == dec_nf);

   mcyc_addr #(
      .AW(AW), .DW(DW), .RESET_PC(RESET_PC), .PORT_MIRROR(PORT_MIRROR)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .asel   (cur.asel),
      .pc_inc (cyc_done && (cur.asel == A_PC)),
      .pair   (pair_addr),
      .port   (data_q),
      .addr   (addr_w),
      .pc     (pc)
   );

   mcyc_tacc #(
      .TW(TW), .T_FETCH(T_FETCH), .T_BUS(T_BUS)
   ) u_tacc (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (cyc_done),
      .is_fetch (cur.kind == K_FETCH),
      .clear    (is_last || is_bad),
      .total    (instr_tstates)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         idx_q    <= '0;
         opcode_q <= '0;
         data_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: st_q <= ST_ISSUE;
            ST_ISSUE: begin
               if (bus_done) begin
                  st_q <= ST_NEXT;
                  if (cur.kind == K_FETCH) opcode_q <= bus_rdata;
                  else                     data_q   <= bus_rdata;
               end
            end
            ST_NEXT: begin
               st_q <= ST_ISSUE;
               if (is_bad || is_last) idx_q <= '0;
               else                   idx_q <= idx_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req      = (st_q == ST_ISSUE);
   assign bus_kind     = cur.kind;
   assign bus_addr     = addr_w;
   assign bus_wdata    = (cur.kind == K_MWR || cur.kind == K_IOWR) ? acc_data : '0;
   assign instr_done   = is_last;
   assign err_flag     = is_bad;
   assign result_valid = is_last && dec_want;
   assign result_data  = data_q;
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk #(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int TW       = 5,
   parameter int T_FETCH  = 4,
   parameter int T_BUS    = 3,
   parameter int RESET_PC = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic [2:0]    bus_kind,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          bus_done,
   input logic [DW-1:0] acc_data,
   input logic [AW-1:0] pc,
   input logic          instr_done,
   input logic [TW-1:0] instr_tstates,
   input logic          result_valid,
   input logic          err_flag
);
   logic       started;
   logic [3:0] ndone;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started <= 1'b0;
         ndone   <= '0;
      end else begin
         if (bus_req && bus_done) started <= 1'b1;
         if (instr_done || err_flag) ndone <= '0;
         else if (bus_req && bus_done) ndone <= ndone + 1'b1;
      end
   end

   a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (!started && bus_req) |-> (bus_kind == 3'd0 && bus_addr == AW'(RESET_PC)));

   a_r2_fetch_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done || err_flag) |=> (bus_req && bus_kind == 3'd0 && bus_addr == pc));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_done) |=> (bus_req && $stable(bus_kind) && $stable(bus_addr) && $stable(bus_wdata)));

   a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_done) |=> !bus_req);

   a_r7_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_kind == 3'd4) |-> (bus_wdata == acc_data));

   a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_done && bus_addr == pc) |=> (pc == $past(pc) + 1'b1));

   a_r8_pc_still: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && bus_done) |=> $stable(pc));

   a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> !instr_done);

   a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> !err_flag);

   a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |-> (int'(instr_tstates) == T_FETCH + T_BUS * (int'(ndone) - 1)));

   a_r11_result: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> instr_done);
endmodule

bind mcyc_seq mcyc_seq_chk #(
   .AW(AW), .DW(DW), .TW(TW), .T_FETCH(T_FETCH), .T_BUS(T_BUS), .RESET_PC(RESET_PC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_kind(bus_kind),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
   .acc_data(acc_data), .pc(pc), .instr_done(instr_done),
   .instr_tstates(instr_tstates), .result_valid(result_valid), .err_flag(err_flag)
);

// File: tb/tb_mcyc_seq.sv
`timescale 1ns/1ps
module tb_mcyc_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req;
   logic [2:0]  bus_kind;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_done = 1'b0;
   logic [7:0]  bus_rdata = 8'h00;
   logic [15:0] pair_addr = 16'h0000;
   logic [7:0]  acc_data = 8'h00;
   logic [15:0] pc;
   logic        instr_done;
   logic [4:0]  instr_tstates;
   logic        result_valid;
   logic [7:0]  result_data;
   logic        err_flag;

   mcyc_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_kind(bus_kind),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
      .bus_rdata(bus_rdata), .pair_addr(pair_addr), .acc_data(acc_data),
      .pc(pc), .instr_done(instr_done), .instr_tstates(instr_tstates),
      .result_valid(result_valid), .result_data(result_data), .err_flag(err_flag)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int lat = 0;
   int wcnt = 0;
   int nlog = 0;
   logic [7:0]  mem [0:255];
   logic [7:0]  io  [0:255];
   logic [2:0]  log_kind [0:15];
   logic [15:0] log_addr [0:15];
   logic [7:0]  log_wd   [0:15];
   logic        e_done, e_err, e_rv;
   logic [7:0]  e_res;
   logic [4:0]  e_ts;
   logic [15:0] e_pc;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   initial begin : responder
      forever begin
         @(negedge clk);
         if (!rst_n || !bus_req || bus_done) begin
            bus_done = 1'b0;
            wcnt = 0;
         end else if (wcnt >= lat) begin
            bus_done = 1'b1;
            wcnt = 0;
            if (bus_kind == 3'd3) bus_rdata = io[bus_addr[7:0]];
            else                  bus_rdata = mem[bus_addr[7:0]];
            if (nlog < 16) begin
               log_kind[nlog] = bus_kind;
               log_addr[nlog] = bus_addr;
               log_wd[nlog]   = bus_wdata;
            end
            nlog++;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'h00;
         io[i]  = 8'h00;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      nlog = 0;
      rst_n = 1'b1;
   endtask

   task automatic run_one();
      e_done = 1'b0;
      e_err  = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (instr_done || err_flag) begin
            e_done = instr_done;
            e_err  = err_flag;
            e_rv   = result_valid;
            e_res  = result_data;
            e_ts   = instr_tstates;
            e_pc   = pc;
            break;
         end
      end
   endtask

   task automatic wait_req();
      for (int i = 0; i < 50; i++) begin
         if (bus_req) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      clear_mem();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(bus_req == 1'b0, "R1", "req in reset", bus_req, 0);
      chk(pc == 16'h0000, "R1", "pc in reset", pc, 0);
      chk(instr_done == 1'b0 && err_flag == 1'b0, "R1", "flags in reset", {instr_done, err_flag}, 0);
      rst_n = 1'b1;
      nlog = 0;
      wait_req();
      chk(bus_req && bus_kind == 3'd0, "R1", "first kind", bus_kind, 0);
      chk(bus_addr == 16'h0000, "R1", "first addr", bus_addr, 0);
   endtask

   task automatic t_mvi();
      clear_mem();
      mem[0] = 8'h3E; mem[1] = 8'h5A;
      lat = 1;
      do_reset();
      run_one();
      chk(e_done && !e_err, "R4", "done", e_done, 1);
      chk(e_res == 8'h5A && e_rv, "R4", "immediate", e_res, 8'h5A);
      chk(e_ts == 5'd7, "R10", "mvi states", e_ts, 7);
      chk(e_pc == 16'h0002, "R8", "mvi pc", e_pc, 2);
      chk(nlog == 2, "R4", "cycle count", nlog, 2);
      chk(log_kind[0] == 3'd0 && log_addr[0] == 16'h0000, "R4", "fetch", log_addr[0], 0);
      chk(log_kind[1] == 3'd1 && log_addr[1] == 16'h0001, "R4", "operand read", log_addr[1], 1);
      wait_req();
      chk(bus_kind == 3'd0 && bus_addr == 16'h0002, "R2", "next fetch", bus_addr, 2);
   endtask

   task automatic t_movm();
      clear_mem();
      mem[0] = 8'h46; mem[8'h80] = 8'hC3;
      pair_addr = 16'h0080;
      lat = 2;
      do_reset();
      run_one();
      chk(e_done && e_rv && e_res == 8'hC3, "R5", "pair data", e_res, 8'hC3);
      chk(e_ts == 5'd7, "R5", "states", e_ts, 7);
      chk(e_pc == 16'h0001, "R8", "pc after pair read", e_pc, 1);
      chk(log_kind[1] == 3'd1 && log_addr[1] == 16'h0080, "R5", "pair addr", log_addr[1], 16'h0080);
   endtask

   task automatic t_in();
      clear_mem();
      mem[0] = 8'hDB; mem[1] = 8'h21; io[8'h21] = 8'h77;
      lat = 0;
      do_reset();
      run_one();
      chk(e_done && e_rv && e_res == 8'h77, "R6", "port data", e_res, 8'h77);
      chk(e_ts == 5'd10, "R10", "in states", e_ts, 10);
      chk(nlog == 3, "R6", "cycle count", nlog, 3);
      chk(log_kind[2] == 3'd3, "R6", "io read kind", log_kind[2], 3);
      chk(log_addr[2] == 16'h2121, "R6", "port addr", log_addr[2], 16'h2121);
      chk(e_pc == 16'h0002, "R8", "in pc", e_pc, 2);
   endtask

   task automatic t_out();
      clear_mem();
      mem[0] = 8'hD3; mem[1] = 8'h44;
      acc_data = 8'h9E;
      lat = 3;
      do_reset();
      run_one();
      chk(e_done && !e_rv, "R11", "no result on out", e_rv, 0);
      chk(e_ts == 5'd10, "R7", "out states", e_ts, 10);
      chk(log_kind[2] == 3'd4 && log_addr[2] == 16'h4444, "R7", "io write addr", log_addr[2], 16'h4444);
      chk(log_wd[2] == 8'h9E, "R7", "io write data", log_wd[2], 8'h9E);
      chk(log_kind[1] == 3'd1 && log_addr[1] == 16'h0001, "R7", "port byte read", log_addr[1], 1);
   endtask

   task automatic t_bad();
      clear_mem();
      mem[0] = 8'h00; mem[1] = 8'h3E; mem[2] = 8'h11;
      lat = 1;
      do_reset();
      run_one();
      chk(e_err && !e_done, "R9", "error raised", e_err, 1);
      chk(e_pc == 16'h0001, "R9", "pc after bad", e_pc, 1);
      @(negedge clk);
      chk(err_flag == 1'b0, "R9", "error one cycle", err_flag, 0);
      run_one();
      chk(e_done && e_res == 8'h11, "R9", "recovered fetch", e_res, 8'h11);
      chk(e_ts == 5'd7, "R10", "count restarts after error", e_ts, 7);
      chk(log_kind[1] == 3'd0 && log_addr[1] == 16'h0001, "R2", "fetch after error", log_addr[1], 1);
   endtask

   task automatic t_chain();
      clear_mem();
      mem[0] = 8'h3E; mem[1] = 8'hA5;
      mem[2] = 8'hDB; mem[3] = 8'h07; io[7] = 8'h3C;
      lat = 2;
      do_reset();
      run_one();
      chk(e_res == 8'hA5 && e_ts == 5'd7, "R4", "first of chain", e_res, 8'hA5);
      run_one();
      chk(e_res == 8'h3C && e_rv, "R6", "second of chain", e_res, 8'h3C);
      chk(e_ts == 5'd10, "R10", "second count", e_ts, 10);
      chk(log_addr[4] == 16'h0707 && log_kind[2] == 3'd0, "R3", "ordered cycles", log_addr[4], 16'h0707);
      chk(e_pc == 16'h0004, "R8", "chain pc", e_pc, 4);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_mvi();
      t_movm();
      t_in();
      t_out();
      t_bad();
      t_chain();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule